// File: doc/BRIEF.md
# Dual-Channel Two-Phase Pulse Generator

This block produces two independent rectangular waveforms. Each channel builds its own tick from a chosen source strobe: a selector picks one of several source-enable strobes, a 7-bit prescaler divides it, and a gate can stop it. A phase counter on each channel spends a programmed number of ticks driving the output high, then a programmed number driving it low, and repeats. All strobes are clock enables in the single `clk` domain, so the whole block runs on one clock.

Software programs the block through a write-only port with three words. Address 0 is a control word shared by both channels. It holds each channel's run bit, source select, prescaler value, tick gate and exact-length bit. Address 1 is channel A's count word and address 2 is channel B's. A count word holds the high count in bits starting at 16 and the low count in bits starting at 0. A new count word is held in a staging register until the running period ends, so no period mixes old and new counts.

By default each phase runs one tick longer than its count. A high count of all ones with a low count of 0 therefore gives one low tick per period. When a channel's exact-length bit is set, each phase lasts exactly its count. A zero count then removes that phase, which gives a true 0% or 100% output.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset both `pwm_out` bits are 0.
- R2: In default mode (exact-length bit clear) a running channel's high time is (high count + 1) ticks and its low time is (low count + 1) ticks.
- R3: The prescaler field (control bits 14:8 for A, 22:16 for B) divides the selected strobe by (value + 1), so one tick occurs every (value + 1) selected strobes. A value of 0 passes every strobe through.
- R4: The source select field (bits 5:4 for A, 7:6 for B) picks `src_tick[sel]` as the channel's strobe.
- R5: While a channel's tick gate (bit 15 for A, bit 23 for B) is 0, that channel receives no ticks and its output holds its level.
- R6: While a channel's run bit (bit 0 for A, bit 1 for B) is 0, its output is 0. When the run bit is set again, the channel starts with a complete high phase.
- R7: In default mode, a high count of all ones with a low count of 0 gives a low time of exactly one tick in every period.
- R8: With the exact-length bit set (bit 28 for A, bit 29 for B), the high time is exactly the high count and the low time is exactly the low count, in ticks.
- R9: In exact-length mode, a high count of 0 holds the output at 0, and a nonzero high count with a low count of 0 holds it at 1.
- R10: A count word written while a channel runs takes effect only at the start of that channel's next high phase. The phase in progress and the rest of the current period keep the old counts.
- R11: Count word address 1 updates only channel A and address 2 updates only channel B. The high count sits at bits 16 and up and the low count at bits 0 and up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NSRC | Source-enable strobes that the selectors choose from |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 count A, 2 count B |
| wr_data | input | 32 | Write data |
| pwm_out | output | 2 | Registered waveform outputs; bit 0 is channel A, bit 1 is channel B |

## Verification
The assertions assume that `src_tick` bits are single-cycle enables in the `clk` domain. They also assume that the exact-length bit is not toggled in the same cycle as a hold check, because that bit acts on the running channel at once.

The bench drives the strobes as fixed-rate enables: every cycle, every second cycle, and every third cycle. It changes a channel's mode only while that channel's run bit is 0. The measured phase lengths in `clk` cycles are therefore exact products of count, prescaler and strobe rate. The bench sweeps counts that include 0 and the maximum of a 4-bit count configuration.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int NCH    = 2;
  localparam int DIV_W  = 7;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNTA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNTB = 2'd2;

  // control-word field positions per channel
  function automatic int run_bit(input int ch);
    return ch;
  endfunction
  function automatic int sel_lsb(input int ch);
    return (ch == 0) ? 4 : 6;
  endfunction
  function automatic int div_lsb(input int ch);
    return (ch == 0) ? 8 : 16;
  endfunction
  function automatic int gate_bit(input int ch);
    return (ch == 0) ? 15 : 23;
  endfunction
  function automatic int exact_bit(input int ch);
    return (ch == 0) ? 28 : 29;
  endfunction
endpackage

// File: rtl/dpwm_tick.sv
module dpwm_tick #(
  parameter int NSRC  = 4,
  parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             gate,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt;
  logic             strobe;
  logic             last;

  always_comb begin
    strobe = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel == SEL_W'(i)) strobe = src_tick[i];
  end

  assign last = (dcnt >= div);
  assign tick = gate & strobe & last;

  always_ff @(posedge clk) begin
    if (rst || !gate)
      dcnt <= '0;
    else if (strobe)
      dcnt <= last ? '0 : dcnt + 1'b1;
  end

  // R5
  gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (dcnt == '0));
endmodule

// File: rtl/dpwm_phase.sv
module dpwm_phase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             exact,
  input  logic             tick,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_hi,
  input  logic [CNT_W-1:0] ld_lo,
  output logic             out_q
);
  localparam int PW = CNT_W + 2;

  logic [CNT_W-1:0] st_hi, st_lo, act_hi, act_lo;
  logic [PW-1:0]    pos, per, hlen, ext;
  logic             wrap;

  assign ext  = exact ? PW'(0) : PW'(1);
  assign hlen = PW'(act_hi) + ext;
  assign per  = PW'(act_hi) + PW'(act_lo) + (ext << 1);
  assign wrap = (per == '0) || (pos >= per - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_hi  <= '0;
      st_lo  <= '0;
      act_hi <= '0;
      act_lo <= '0;
      pos    <= '0;
      out_q  <= 1'b0;
    end else begin
      if (ld_we) begin
        st_hi <= ld_hi;
        st_lo <= ld_lo;
      end
      if (!run) begin
        pos    <= '0;
        act_hi <= st_hi;
        act_lo <= st_lo;
      end else if (tick) begin
        if (wrap) begin
          pos    <= '0;
          act_hi <= st_hi;
          act_lo <= st_lo;
        end else begin
          pos <= pos + 1'b1;
        end
      end
      out_q <= run && (pos < hlen);
    end
  end

  // R6
  run_off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !out_q);
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pos == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !tick && !$past(tick) && !$past(rst) && $stable(exact))
      |=> $stable(out_q));
  // R10
  hold_counts_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !(tick && wrap)) |=> ($stable(act_hi) && $stable(act_lo)));
  // R9
  const_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (exact && act_hi == '0) |=> !out_q);
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpwm_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NCH-1:0]       pwm_out
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [REG_W-1:0] ctrl;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL)
      ctrl <= wr_data;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = (c == 0) ? ADDR_CNTA : ADDR_CNTB;
    logic tick;

    dpwm_tick #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_tick (
      .clk      (clk),
      .rst      (rst),
      .src_tick (src_tick),
      .sel      (ctrl[sel_lsb(c) +: SEL_W]),
      .div      (ctrl[div_lsb(c) +: DIV_W]),
      .gate     (ctrl[gate_bit(c)]),
      .tick     (tick)
    );

    dpwm_phase #(.CNT_W(CNT_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .run   (ctrl[run_bit(c)]),
      .exact (ctrl[exact_bit(c)]),
      .tick  (tick),
      .ld_we (wr_en && wr_addr == MY_ADDR),
      .ld_hi (wr_data[16 +: CNT_W]),
      .ld_lo (wr_data[0 +: CNT_W]),
      .out_q (pwm_out[c])
    );
  end
endmodule

// File: tb/sim_dual_phase_pwm.sv
module sim_dual_phase_pwm;
  localparam int NSRC = 4;
  localparam int CW   = 4;
  localparam int LIM  = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = 4'b0001;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  dual_phase_pwm #(.NSRC(NSRC), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // strobes: every cycle, every 2nd, every 3rd, never
  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick[0] <= 1'b1;
    src_tick[1] <= ((cyc + 1) % 2 == 0);
    src_tick[2] <= ((cyc + 1) % 3 == 0);
    src_tick[3] <= 1'b0;
  end

  always @(negedge clk) begin
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int ch, input bit run, input int sel,
                                      input int dv, input bit gate, input bit ex);
    logic [31:0] w = '0;
    if (ch == 0) begin
      w[0] = run; w[5:4] = 2'(sel); w[14:8] = 7'(dv); w[15] = gate; w[28] = ex;
    end else begin
      w[1] = run; w[7:6] = 2'(sel); w[22:16] = 7'(dv); w[23] = gate; w[29] = ex;
    end
    return w;
  endfunction

  function automatic logic [31:0] cw(input int hi, input int lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  task automatic meas(input int ch, output int th, output int tl);
    int n;
    th = 0; tl = 0;
    n = 0; while (pwm_out[ch] !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
    n = 0; while (pwm_out[ch] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (pwm_out[ch] === 1'b1 && th < LIM) begin th++; @(negedge clk); end
    while (pwm_out[ch] === 1'b0 && tl < LIM) begin tl++; @(negedge clk); end
  endtask

  task automatic setup(input int ch, input int hi, input int lo, input int sel,
                       input int dv, input bit ex);
    wr(2'd0, 32'h0);
    wr(2'(ch + 1), cw(hi, lo));
    wr(2'd0, mk(ch, 1'b0, sel, dv, 1'b1, ex));
    wr(2'd0, mk(ch, 1'b1, sel, dv, 1'b1, ex));
  endtask

  task automatic hold_check(input int ch, input logic lvl, input int len, input string tag);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out[ch] !== lvl) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int th, tl, r, eh, el, ch, rem;
    int vals_d[3] = '{0, 3, 15};
    int vals_c[3] = '{1, 4, 15};
    int sels[2]   = '{0, 2};
    int divs[2]   = '{0, 2};
    int k = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwm_out == 2'b00, "R1 reset output", int'(pwm_out), 0);

    // R2 R3 R4 R7 default-mode sweep
    foreach (vals_d[i]) foreach (vals_d[j]) foreach (sels[s]) foreach (divs[d]) begin
      ch = k % 2; k++;
      r  = sels[s] + 1;
      setup(ch, vals_d[i], vals_d[j], sels[s], divs[d], 1'b0);
      meas(ch, th, tl);
      meas(ch, th, tl);
      eh = (vals_d[i] + 1) * (divs[d] + 1) * r;
      el = (vals_d[j] + 1) * (divs[d] + 1) * r;
      chk(th == eh, "R2 R3 R4 default high time", th, eh);
      chk(tl == el, "R2 R3 R4 default low time", tl, el);
    end

    // R7 full high count, zero low count
    setup(0, 15, 0, 0, 0, 1'b0);
    meas(0, th, tl); meas(0, th, tl);
    chk(tl == 1, "R7 single low tick", tl, 1);
    chk(th == 16, "R7 high time", th, 16);

    // R8 exact-length sweep
    foreach (vals_c[i]) foreach (vals_c[j]) foreach (sels[s]) foreach (divs[d]) begin
      ch = k % 2; k++;
      r  = sels[s] + 1;
      setup(ch, vals_c[i], vals_c[j], sels[s], divs[d], 1'b1);
      meas(ch, th, tl);
      meas(ch, th, tl);
      eh = vals_c[i] * (divs[d] + 1) * r;
      el = vals_c[j] * (divs[d] + 1) * r;
      chk(th == eh, "R8 exact high time", th, eh);
      chk(tl == el, "R8 exact low time", tl, el);
    end

    // R9 constant levels
    setup(0, 5, 0, 0, 0, 1'b1);
    repeat (4) @(negedge clk);
    hold_check(0, 1'b1, 200, "R9 constant high");
    setup(1, 0, 5, 0, 0, 1'b1);
    repeat (4) @(negedge clk);
    hold_check(1, 1'b0, 200, "R9 constant low");
    setup(0, 0, 0, 0, 0, 1'b1);
    repeat (4) @(negedge clk);
    hold_check(0, 1'b0, 100, "R9 both counts zero");

    // R5 gate off freezes a high output
    setup(0, 7, 7, 0, 0, 1'b0);
    meas(0, th, tl);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    wr(2'd0, mk(0, 1'b1, 0, 0, 1'b0, 1'b0));
    @(negedge clk);
    hold_check(0, 1'b1, 100, "R5 gate off holds high");
    wr(2'd0, mk(0, 1'b1, 0, 0, 1'b1, 1'b0));
    meas(0, th, tl); meas(0, th, tl);
    chk(th == 8 && tl == 8, "R5 resumes after gate on", th * 100 + tl, 808);

    // R6 run off forces low, restart gives a full high phase
    wr(2'd0, mk(0, 1'b0, 0, 0, 1'b1, 1'b0));
    @(negedge clk);
    hold_check(0, 1'b0, 50, "R6 run off low");
    wr(2'd0, mk(0, 1'b1, 0, 0, 1'b1, 1'b0));
    th = 0;
    while (pwm_out[0] !== 1'b1 && th < LIM) begin @(negedge clk); th++; end
    th = 0;
    while (pwm_out[0] === 1'b1 && th < LIM) begin th++; @(negedge clk); end
    chk(th == 8, "R6 first high phase after restart", th, 8);

    // R10 staged counts: write during low phase
    setup(0, 3, 3, 0, 0, 1'b0);
    meas(0, th, tl);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    while (pwm_out[0] !== 1'b0) @(negedge clk);
    wr(2'd1, cw(9, 9));
    rem = 0;
    while (pwm_out[0] === 1'b0 && rem < LIM) begin rem++; @(negedge clk); end
    chk(rem == 3, "R10 current low keeps old count", rem, 3);
    th = 0;
    while (pwm_out[0] === 1'b1 && th < LIM) begin th++; @(negedge clk); end
    chk(th == 10, "R10 next high uses new count", th, 10);

    // R11 channel B count write leaves channel A unchanged
    wr(2'd2, cw(1, 12));
    meas(0, th, tl); meas(0, th, tl);
    chk(th == 10 && tl == 10, "R11 A unaffected by B write", th * 100 + tl, 1010);
    wr(2'd0, mk(0, 1'b1, 0, 0, 1'b1, 1'b0) | mk(1, 1'b1, 0, 0, 1'b1, 1'b0));
    meas(1, th, tl); meas(1, th, tl);
    chk(th == 2 && tl == 13, "R11 B takes its own word", th * 100 + tl, 213);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule